// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block works out where the instruction pointer goes next in a processor with a 12-bit instruction address space. It takes the decoded opcode byte, the two operand bytes after it, the value of the register that the opcode selects, the 4-bit flag register and the address of the next sequential instruction. From these it forms the next pointer for absolute jumps, jumps offset by a register, plain forward and backward skips, and forward and backward skips that depend on a flag.

A skip moves the pointer by an unsigned 8-bit distance. The distance is counted from the sequential address, which already lies past the two-byte branch. A backward skip of 2 therefore lands on the branch itself and holds the program in place. A conditional skip carries its direction, its test sense and the flag it tests in the low nibble of the opcode. The unit reports whether the branch is taken. It also holds the pointer register, which takes the computed value whenever the surrounding core finishes an instruction.

Top module: `brnext_unit`

## Requirements
- R1: Opcode 11000xxx is taken, and the next pointer is the absolute target {byte2[3:0], byte3}.
- R2: Opcode 11001xxx is taken, and the next pointer is the absolute target plus the zero-extended 8-bit register value, modulo 4096.
- R3: Opcode 11100xxx is taken, and the next pointer is the sequential address plus byte2 as an unsigned value, modulo 4096.
- R4: Opcode 11101xxx is taken, and the next pointer is the sequential address minus byte2 as an unsigned value, modulo 4096.
- R5: Opcode 1111dsff is taken when flag bit ff equals s. The flag bits are 0 = carry, 1 = overflow, 2 = interrupt enable and 3 = user. When taken, the next pointer is the sequential address plus byte2 if d=0, or minus byte2 if d=1, modulo 4096.
- R6: A conditional opcode that is not taken reports taken=0 and gives the sequential address as the next pointer.
- R7: Every other opcode reports taken=0 and gives the sequential address as the next pointer, whatever the values of byte2, byte3, the register and the flags.
- R8: A taken backward skip with byte2 = 2 gives the sequential address minus 2, which is the address of the branch itself.
- R9: The pointer register is 0 while rst_n is low, and it clears as soon as rst_n falls, without waiting for a clock edge.
- R10: On a rising clock edge with adv_i high, the pointer register loads the next pointer. With adv_i low it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Current instruction has finished; load the pointer |
| op_i | input | 8 | Opcode byte |
| byte2_i | input | 8 | Second instruction byte (skip distance, or high target nibble) |
| byte3_i | input | 8 | Third instruction byte (low target byte) |
| reg_i | input | 8 | Value of the register the opcode selects |
| flags_i | input | 4 | Flag register: carry, overflow, interrupt enable, user |
| seq_ptr_i | input | 12 | Address of the next sequential instruction |
| next_ptr_o | output | 12 | Computed next pointer |
| taken_o | output | 1 | Branch taken |
| ptr_q_o | output | 12 | Registered instruction pointer |

## Verification
The bench drives all 256 opcode values against all 16 flag combinations. Each pairing runs under three operand patterns. The first places the sequential address near the top of the space with a large distance, which exposes forward and register-offset wraparound. The second places it near zero, which exposes backward wraparound. The third is an arithmetic mix that varies from opcode to opcode. Because all opcodes and all flag values are covered, a swapped direction bit, an inverted sense, a wrong flag index or a decode that claims an extra opcode each give a wrong pointer or a wrong taken bit. Separate cases check the self-loop distance and the pointer register's reset, load and hold behaviour.

// File: rtl/brnext_pkg.sv
package brnext_pkg;
   typedef enum logic [2:0] {
      BK_NONE,
      BK_JABS,
      BK_JREG,
      BK_FWD,
      BK_BWD,
      BK_CFWD,
      BK_CBWD
   } br_kind_e;
endpackage

// File: rtl/brnext_decode.sv
module brnext_decode
   import brnext_pkg::*;
#(
   parameter int OP_W   = 8,
   parameter int FSEL_W = 2
) (
   input  logic [OP_W-1:0]   op_i,
   output br_kind_e          kind_o,
   output logic              sense_o,
   output logic [FSEL_W-1:0] fsel_o
);
   if (OP_W != 8) begin : g_bad_op
      $error("brnext_decode: opcode must be 8 bits");
   end
   if (FSEL_W < 1 || FSEL_W > 2) begin : g_bad_fsel
      $error("brnext_decode: flag index must fit in two opcode bits");
   end

   always_comb begin
      casez (op_i)
         8'b11000???: kind_o = BK_JABS;
         8'b11001???: kind_o = BK_JREG;
         8'b11100???: kind_o = BK_FWD;
         8'b11101???: kind_o = BK_BWD;
         8'b11110???: kind_o = BK_CFWD;
         8'b11111???: kind_o = BK_CBWD;
         default:     kind_o = BK_NONE;
      endcase
   end

   assign sense_o = op_i[2];
   assign fsel_o  = op_i[FSEL_W-1:0];
endmodule

// File: rtl/brnext_cond.sv
module brnext_cond #(
   parameter int FLAG_W = 4,
   localparam int FSEL_W = $clog2(FLAG_W)
) (
   input  logic [FLAG_W-1:0] flags_i,
   input  logic              sense_i,
   input  logic [FSEL_W-1:0] fsel_i,
   output logic              hit_o
);
   if (FLAG_W != (1 << FSEL_W)) begin : g_bad_flags
      $error("brnext_cond: flag count must be a power of two");
   end

   logic [FLAG_W-1:0] match;

   for (genvar i = 0; i < FLAG_W; i++) begin : g_match
      assign match[i] = (flags_i[i] == sense_i);
   end

   assign hit_o = match[fsel_i];
endmodule

// File: rtl/brnext_target.sv
module brnext_target
   import brnext_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int OFF_W        = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  br_kind_e          kind_i,
   input  logic              hit_i,
   input  logic [ADDR_W-1:0] seq_i,
   input  logic [ADDR_W-1:0] abs_i,
   input  logic [OFF_W-1:0]  off_i,
   input  logic [OFF_W-1:0]  reg_i,
   output logic [ADDR_W-1:0] next_o,
   output logic              taken_o
);
   localparam int PAD_W = ADDR_W - OFF_W;

   if (PAD_W < 1) begin : g_bad_w
      $error("brnext_target: address must be wider than the offset");
   end

   logic [ADDR_W-1:0] off_x;
   logic [ADDR_W-1:0] reg_x;
   logic [ADDR_W-1:0] moved;

   assign off_x = {{PAD_W{1'b0}}, off_i};
   assign reg_x = {{PAD_W{1'b0}}, reg_i};

   always_comb begin
      case (kind_i)
         BK_JABS, BK_JREG, BK_FWD, BK_BWD: taken_o = 1'b1;
         BK_CFWD, BK_CBWD:                 taken_o = hit_i;
         default:                          taken_o = 1'b0;
      endcase
   end

   if (SHARED_ADDER) begin : g_shared
      logic [ADDR_W-1:0] base;
      logic [ADDR_W-1:0] addend;
      logic [ADDR_W-1:0] carry_in;
      logic              sub;

      always_comb begin
         sub  = (kind_i == BK_BWD) || (kind_i == BK_CBWD);
         base = ((kind_i == BK_JABS) || (kind_i == BK_JREG)) ? abs_i : seq_i;
         case (kind_i)
            BK_JABS: addend = '0;
            BK_JREG: addend = reg_x;
            default: addend = off_x;
         endcase
         carry_in = {{(ADDR_W-1){1'b0}}, sub};
      end

      assign moved = base + (sub ? ~addend : addend) + carry_in;
   end else begin : g_parallel
      logic [ADDR_W-1:0] jreg_sum;
      logic [ADDR_W-1:0] fwd_sum;
      logic [ADDR_W-1:0] bwd_dif;

      assign jreg_sum = abs_i + reg_x;
      assign fwd_sum  = seq_i + off_x;
      assign bwd_dif  = seq_i - off_x;

      always_comb begin
         case (kind_i)
            BK_JABS:          moved = abs_i;
            BK_JREG:          moved = jreg_sum;
            BK_BWD, BK_CBWD:  moved = bwd_dif;
            default:          moved = fwd_sum;
         endcase
      end
   end

   assign next_o = taken_o ? moved : seq_i;
endmodule

// File: rtl/brnext_unit.sv
module brnext_unit
   import brnext_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int DATA_W       = 8,
   parameter int FLAG_W       = 4,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_i,
   input  logic [DATA_W-1:0] op_i,
   input  logic [DATA_W-1:0] byte2_i,
   input  logic [DATA_W-1:0] byte3_i,
   input  logic [DATA_W-1:0] reg_i,
   input  logic [FLAG_W-1:0] flags_i,
   input  logic [ADDR_W-1:0] seq_ptr_i,
   output logic [ADDR_W-1:0] next_ptr_o,
   output logic              taken_o,
   output logic [ADDR_W-1:0] ptr_q_o
);
   localparam int HI_W   = ADDR_W - DATA_W;
   localparam int FSEL_W = $clog2(FLAG_W);

   if (HI_W < 1 || HI_W > DATA_W) begin : g_bad_addr
      $error("brnext_unit: address width must lie between one and two bytes");
   end

   br_kind_e          kind;
   logic              sense;
   logic [FSEL_W-1:0] fsel;
   logic              hit;
   logic [ADDR_W-1:0] abs_tgt;

   assign abs_tgt = {byte2_i[HI_W-1:0], byte3_i};

   brnext_decode #(
      .OP_W   (DATA_W),
      .FSEL_W (FSEL_W)
   ) u_dec (
      .op_i    (op_i),
      .kind_o  (kind),
      .sense_o (sense),
      .fsel_o  (fsel)
   );

   brnext_cond #(
      .FLAG_W (FLAG_W)
   ) u_cond (
      .flags_i (flags_i),
      .sense_i (sense),
      .fsel_i  (fsel),
      .hit_o   (hit)
   );

   brnext_target #(
      .ADDR_W       (ADDR_W),
      .OFF_W        (DATA_W),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_tgt (
      .kind_i  (kind),
      .hit_i   (hit),
      .seq_i   (seq_ptr_i),
      .abs_i   (abs_tgt),
      .off_i   (byte2_i),
      .reg_i   (reg_i),
      .next_o  (next_ptr_o),
      .taken_o (taken_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q_o <= '0;
      end else if (adv_i) begin
         ptr_q_o <= next_ptr_o;
      end
   end
endmodule

// File: rtl/brnext_chk.sv
module brnext_chk #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8,
   parameter int FLAG_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              adv_i,
   input logic [DATA_W-1:0] op_i,
   input logic [DATA_W-1:0] byte2_i,
   input logic [DATA_W-1:0] byte3_i,
   input logic [DATA_W-1:0] reg_i,
   input logic [FLAG_W-1:0] flags_i,
   input logic [ADDR_W-1:0] seq_ptr_i,
   input logic [ADDR_W-1:0] next_ptr_o,
   input logic              taken_o,
   input logic [ADDR_W-1:0] ptr_q_o
);
   localparam int HI_W = ADDR_W - DATA_W;
   localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

   logic [ADDR_W-1:0] self_loop;
   logic              is_cond;
   logic              is_other;

   assign self_loop = seq_ptr_i - TWO;
   assign is_cond   = (op_i[7:4] == 4'hF);
   assign is_other  = !is_cond && (op_i[7:3] != 5'b11000) && (op_i[7:3] != 5'b11001)
                      && (op_i[7:3] != 5'b11100) && (op_i[7:3] != 5'b11101);

   // R1
   jmp_abs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i[7:3] == 5'b11000) |-> (taken_o && next_ptr_o == {byte2_i[HI_W-1:0], byte3_i}));

   // R5
   cond_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_cond |-> (taken_o == (flags_i[op_i[1:0]] == op_i[2])));

   // R6
   cond_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cond && !taken_o) |-> (next_ptr_o == seq_ptr_i));

   // R7
   other_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_other |-> (!taken_o && next_ptr_o == seq_ptr_i));

   // R8
   self_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_i[7:3] == 5'b11101 || (is_cond && op_i[3] && taken_o)) && byte2_i == 8'd2)
      |-> (next_ptr_o == self_loop));

   // R10
   ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |=> (ptr_q_o == $past(next_ptr_o)));

   // R10
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(ptr_q_o));
endmodule

bind brnext_unit brnext_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .FLAG_W (FLAG_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .adv_i      (adv_i),
   .op_i       (op_i),
   .byte2_i    (byte2_i),
   .byte3_i    (byte3_i),
   .reg_i      (reg_i),
   .flags_i    (flags_i),
   .seq_ptr_i  (seq_ptr_i),
   .next_ptr_o (next_ptr_o),
   .taken_o    (taken_o),
   .ptr_q_o    (ptr_q_o)
);

// File: tb/brnext_unit_bench.sv
module brnext_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        adv_i = 1'b0;
   logic [7:0]  op_i = '0;
   logic [7:0]  byte2_i = '0;
   logic [7:0]  byte3_i = '0;
   logic [7:0]  reg_i = '0;
   logic [3:0]  flags_i = '0;
   logic [11:0] seq_ptr_i = '0;
   logic [11:0] next_ptr_o;
   logic        taken_o;
   logic [11:0] ptr_q_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   brnext_unit u_brnext_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv_i      (adv_i),
      .op_i       (op_i),
      .byte2_i    (byte2_i),
      .byte3_i    (byte3_i),
      .reg_i      (reg_i),
      .flags_i    (flags_i),
      .seq_ptr_i  (seq_ptr_i),
      .next_ptr_o (next_ptr_o),
      .taken_o    (taken_o),
      .ptr_q_o    (ptr_q_o)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h (op=%0h fl=%0h seq=%0h b2=%0h b3=%0h r=%0h)",
                  req, what, act, exp, op_i, flags_i, seq_ptr_i, byte2_i, byte3_i, reg_i);
      end
   endtask

   function automatic string req_of(input int op);
      if ((op >> 3) == 5'b11000) return "R1";
      if ((op >> 3) == 5'b11001) return "R2";
      if ((op >> 3) == 5'b11100) return "R3";
      if ((op >> 3) == 5'b11101) return "R4";
      if ((op >> 4) == 4'hF)     return "R5/R6";
      return "R7";
   endfunction

   task automatic model(input int op, input int b2, input int b3, input int r,
                        input int fl, input int seq, output int tk, output int nx);
      int abs_t;
      abs_t = ((b2 & 15) << 8) | b3;
      tk = 0;
      nx = seq;
      if ((op >> 3) == 5'b11000) begin
         tk = 1; nx = abs_t;
      end else if ((op >> 3) == 5'b11001) begin
         tk = 1; nx = (abs_t + r) & 4095;
      end else if ((op >> 3) == 5'b11100) begin
         tk = 1; nx = (seq + b2) & 4095;
      end else if ((op >> 3) == 5'b11101) begin
         tk = 1; nx = (seq - b2) & 4095;
      end else if ((op >> 4) == 4'hF) begin
         tk = (((fl >> (op & 3)) & 1) == ((op >> 2) & 1)) ? 1 : 0;
         if (tk == 1) nx = ((op & 8) != 0) ? ((seq - b2) & 4095) : ((seq + b2) & 4095);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL R10 watchdog expired act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      int tk;
      int nx;
      repeat (3) @(negedge clk);
      // R9: pointer is zero while in reset
      check("R9", "ptr in reset", int'(ptr_q_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", "ptr after reset", int'(ptr_q_o), 0);

      // R1..R7: every opcode, every flag value, three operand patterns
      for (int op = 0; op < 256; op++) begin
         for (int fl = 0; fl < 16; fl++) begin
            for (int k = 0; k < 3; k++) begin
               int seq, b2, b3, r;
               if (k == 0) begin
                  seq = 4090; b2 = 8'hCF; b3 = 8'hF7; r = 8'hFF;
               end else if (k == 1) begin
                  seq = 3; b2 = 250; b3 = 8'h12; r = 8'h41;
               end else begin
                  seq = (op * 53 + fl * 7) & 4095;
                  b2  = (op * 29 + fl) & 255;
                  b3  = (op * 17) & 255;
                  r   = (op * 5 + fl * 11) & 255;
               end
               op_i = 8'(op); flags_i = 4'(fl); seq_ptr_i = 12'(seq);
               byte2_i = 8'(b2); byte3_i = 8'(b3); reg_i = 8'(r);
               #1;
               model(op, b2, b3, r, fl, seq, tk, nx);
               check(req_of(op), "taken", int'(taken_o), tk);
               check(req_of(op), "next", int'(next_ptr_o), nx);
            end
         end
      end

      // R8: backward skip of 2 returns to the branch itself
      op_i = 8'hE8; byte2_i = 8'd2; seq_ptr_i = 12'h102; flags_i = 4'h0;
      #1;
      check("R8", "rwnd self loop", int'(next_ptr_o), 12'h100);
      op_i = 8'hFC; flags_i = 4'h1; seq_ptr_i = 12'h001;
      #1;
      check("R8", "conditional self loop wrap", int'(next_ptr_o), 12'hFFF);

      // R10: load on adv, hold without it
      @(negedge clk);
      op_i = 8'hC0; byte2_i = 8'h05; byte3_i = 8'hA3; adv_i = 1'b1;
      @(posedge clk); #1;
      check("R10", "ptr load", int'(ptr_q_o), 12'h5A3);
      @(negedge clk);
      adv_i = 1'b0; byte3_i = 8'h11;
      @(posedge clk); #1;
      check("R10", "ptr hold", int'(ptr_q_o), 12'h5A3);

      // R9: asynchronous clear between edges
      @(negedge clk);
      #2 rst_n = 1'b0;
      #1;
      check("R9", "async clear", int'(ptr_q_o), 0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule